// File: doc/BRIEF.md
# Configurable LFSR Pseudo-Random Generator

This block is a linear feedback shift register used as a cheap pseudo-random source. The register structure and the feedback type are fixed when it is built. The structure is either Fibonacci, where one new bit enters at the bottom, or Galois, where the top bit is folded into every tapped position. The feedback is either XOR or XNOR. The tap positions come from a built-in table of maximal-length polynomials, so the register cycles through every value except one lock-up value.

On each cycle with the enable high, the state moves forward by a fixed number of single steps, set by the `STEPS` parameter. Software or neighbouring logic can replace the state at any time through a valid-qualified seed input. As a build option, that seed is first advanced by the same number of steps. On asynchronous reset, the block either loads a full constant seed or, when no constant is given, drives a single bit to the one value that keeps it out of lock-up. The other bits are left without reset.

Top module: `lfsr_prng`

## Requirements
- R1: In the Fibonacci form, one step shifts the state one place toward the MSB. Bit 0 takes the reduction of the tapped bits, where tap t means bit index t-1.
- R2: In the Galois form, one step sets bit 0 to the old MSB. Each bit i ≥ 1 takes old bit i-1, combined with the old MSB when tap i exists (bit i-1 of the tap mask).
- R3: The reduction is XOR, or XNOR when the feedback parameter selects it. The tap sets are: width 16 {16,14,13,11}, width 8 {8,6,5,4}, width 7 {7,6}, width 5 {5,3}.
- R4: Starting from any state other than the lock-up value, the state never reaches lock-up unless a seed is loaded. Lock-up is all zeros for XOR and all ones for XNOR.
- R5: A cycle with `step_en` high and `seed_vld` low applies exactly `STEPS` single steps. The state differs from its previous value after every such cycle.
- R6: With both `step_en` and `seed_vld` low, the state holds.
- R7: When `seed_vld` is high, the seed is stored at the next edge and `step_en` is ignored in that cycle. With pre-stepping off, the stored value equals `seed_val`.
- R8: With pre-stepping on, the stored value is `seed_val` advanced by `STEPS` single steps.
- R9: With no constant seed, reset drives only bit 0. It is driven to 1 for XOR and to 0 for XNOR.
- R10: With a constant seed, asynchronous reset loads the whole state with that constant.
- R11: After a load, the state first returns to the loaded value after (2^N−1)/gcd(STEPS, 2^N−1) enabled cycles, for width N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Advance the state by STEPS steps this cycle |
| seed_vld | input | 1 | Load the seed this cycle (has priority) |
| seed_val | input | WIDTH | Seed value |
| state_o | output | WIDTH | Current register state |

## Verification
The bench builds four copies side by side. The first is 16 bits wide, Fibonacci, XOR, one step per cycle. The second is 5 bits wide, Galois, XNOR, one step. The third is 8 bits wide, Fibonacci, XNOR, three steps, with a constant seed and pre-stepped loads. The fourth is 7 bits wide, Galois, XOR, two steps, with a constant seed. These small widths let one 65535-cycle run cover the full period of every copy and compare each state against an arithmetic model. The multi-step copies show that the period shrinks by the gcd rule. The two reset styles and both reduction types each meet their own lock-up value.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

   typedef enum logic {
      FORM_FIB    = 1'b0,
      FORM_GALOIS = 1'b1
   } lfsr_form_e;

   typedef enum logic {
      FB_XOR  = 1'b0,
      FB_XNOR = 1'b1
   } lfsr_fb_e;

   localparam int unsigned LFSR_MAX_W = 32;

   // Tap mask: bit (t-1) set for each polynomial term x^t, t = 1..w.
   // Zero means the width is not supported.
   function automatic logic [LFSR_MAX_W-1:0] tap_mask(input int unsigned w);
      logic [LFSR_MAX_W-1:0] m;
      m = '0;
      case (w)
         3:  m = 32'h0000_0006;
         4:  m = 32'h0000_000C;
         5:  m = 32'h0000_0014;
         6:  m = 32'h0000_0030;
         7:  m = 32'h0000_0060;
         8:  m = 32'h0000_00B8;
         9:  m = 32'h0000_0110;
         10: m = 32'h0000_0240;
         11: m = 32'h0000_0500;
         12: m = 32'h0000_0829;
         13: m = 32'h0000_100D;
         14: m = 32'h0000_2015;
         15: m = 32'h0000_6000;
         16: m = 32'h0000_B400;
         17: m = 32'h0001_2000;
         18: m = 32'h0002_0400;
         19: m = 32'h0004_0023;
         20: m = 32'h0009_0000;
         24: m = 32'h00E1_0000;
         32: m = 32'h8020_0003;
         default: m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/lfsr_cell.sv
module lfsr_cell #(
   parameter bit HAS_RST = 1'b0,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (HAS_RST) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= d;
         end
      end else begin : g_norst
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            q <= d;
         end
      end
   endgenerate

endmodule

// File: rtl/lfsr_step1.sv
module lfsr_step1
   import lfsr_pkg::*;
#(
   parameter int unsigned WIDTH    = 16,
   parameter lfsr_form_e  FORM     = FORM_FIB,
   parameter lfsr_fb_e    FEEDBACK = FB_XOR
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] nxt
);

   localparam logic [LFSR_MAX_W-1:0] TAPS_FULL = tap_mask(WIDTH);
   localparam logic [WIDTH-1:0]      TAPS      = TAPS_FULL[WIDTH-1:0];
   localparam logic                  INV       = (FEEDBACK == FB_XNOR);

   generate
      if (FORM == FORM_FIB) begin : g_fib
         logic fb;
         assign fb  = (^(cur & TAPS)) ^ INV;
         assign nxt = {cur[WIDTH-2:0], fb};
      end else begin : g_gal
         logic fb;
         assign fb     = cur[WIDTH-1];
         assign nxt[0] = fb;
         for (genvar i = 1; i < WIDTH; i++) begin : g_bit
            if (TAPS[i-1]) begin : g_tap
               assign nxt[i] = cur[i-1] ^ fb ^ INV;
            end else begin : g_pass
               assign nxt[i] = cur[i-1];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/lfsr_multistep.sv
module lfsr_multistep
   import lfsr_pkg::*;
#(
   parameter int unsigned WIDTH    = 16,
   parameter lfsr_form_e  FORM     = FORM_FIB,
   parameter lfsr_fb_e    FEEDBACK = FB_XOR,
   parameter int unsigned STEPS    = 1
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] nxt
);

   logic [WIDTH-1:0] stage [STEPS+1];

   assign stage[0] = cur;

   generate
      for (genvar k = 0; k < STEPS; k++) begin : g_stage
         lfsr_step1 #(
            .WIDTH   (WIDTH),
            .FORM    (FORM),
            .FEEDBACK(FEEDBACK)
         ) u_step (
            .cur(stage[k]),
            .nxt(stage[k+1])
         );
      end
   endgenerate

   assign nxt = stage[STEPS];

endmodule

// File: rtl/lfsr_prng.sv
module lfsr_prng
   import lfsr_pkg::*;
#(
   parameter int unsigned      WIDTH         = 16,
   parameter lfsr_form_e       FORM          = FORM_FIB,
   parameter lfsr_fb_e         FEEDBACK      = FB_XOR,
   parameter int unsigned      STEPS         = 1,
   parameter bit               SEED_PRESTEP  = 1'b0,
   parameter bit               USE_INIT_SEED = 1'b0,
   parameter logic [WIDTH-1:0] INIT_SEED     = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic             seed_vld,
   input  logic [WIDTH-1:0] seed_val,
   output logic [WIDTH-1:0] state_o
);

   localparam logic [WIDTH-1:0] LOCK_VAL = (FEEDBACK == FB_XNOR) ? '1 : '0;
   localparam logic             SAFE_BIT = (FEEDBACK == FB_XOR);
   localparam longint           PERIOD   = (longint'(1) << WIDTH) - 1;

   // Elaboration-time parameter checks
   generate
      if (WIDTH < 3 || WIDTH > LFSR_MAX_W || tap_mask(WIDTH) == '0) begin : g_bad_width
         $error("lfsr_prng: WIDTH %0d has no tap entry", WIDTH);
      end
      if (STEPS < 1) begin : g_bad_steps
         $error("lfsr_prng: STEPS must be at least 1");
      end
      if ((longint'(STEPS) % PERIOD) == 0) begin : g_bad_period
         $error("lfsr_prng: STEPS is a multiple of the period");
      end
      if (USE_INIT_SEED && INIT_SEED == LOCK_VAL) begin : g_bad_seed
         $error("lfsr_prng: INIT_SEED equals the lock-up value");
      end
   endgenerate

   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] step_nxt;
   logic [WIDTH-1:0] seed_w;
   logic [WIDTH-1:0] state_d;

   lfsr_multistep #(
      .WIDTH   (WIDTH),
      .FORM    (FORM),
      .FEEDBACK(FEEDBACK),
      .STEPS   (STEPS)
   ) u_adv (
      .cur(state_q),
      .nxt(step_nxt)
   );

   generate
      if (SEED_PRESTEP) begin : g_prestep
         lfsr_multistep #(
            .WIDTH   (WIDTH),
            .FORM    (FORM),
            .FEEDBACK(FEEDBACK),
            .STEPS   (STEPS)
         ) u_seed_adv (
            .cur(seed_val),
            .nxt(seed_w)
         );
      end else begin : g_direct
         assign seed_w = seed_val;
      end
   endgenerate

   // Seed load wins over stepping
   always_comb begin
      if (seed_vld)     state_d = seed_w;
      else if (step_en) state_d = step_nxt;
      else              state_d = state_q;
   end

   // One flop per bit so each bit chooses its own reset behaviour
   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_cell
         localparam bit CELL_RST = USE_INIT_SEED || (b == 0);
         localparam bit CELL_VAL = USE_INIT_SEED ? INIT_SEED[b] : SAFE_BIT;
         lfsr_cell #(
            .HAS_RST(CELL_RST),
            .RST_VAL(CELL_VAL)
         ) u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (state_d[b]),
            .q    (state_q[b])
         );
      end
   endgenerate

   assign state_o = state_q;

endmodule

// File: rtl/lfsr_prng_chk.sv
module lfsr_prng_chk
   import lfsr_pkg::*;
#(
   parameter int unsigned WIDTH        = 16,
   parameter lfsr_fb_e    FEEDBACK     = FB_XOR,
   parameter bit          SEED_PRESTEP = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step_en,
   input logic             seed_vld,
   input logic [WIDTH-1:0] seed_val,
   input logic [WIDTH-1:0] state_o
);

   localparam logic [WIDTH-1:0] LOCK_VAL = (FEEDBACK == FB_XNOR) ? '1 : '0;

   // R4: no entry into the lock-up value without a load
   a_r4_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
      (!seed_vld && state_o != LOCK_VAL) |=> state_o != LOCK_VAL);

   // R5: every enabled step changes the state
   a_r5_changes: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !seed_vld && state_o != LOCK_VAL) |=> state_o != $past(state_o));

   // R6: idle cycles hold the state
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_en && !seed_vld) |=> $stable(state_o));

   generate
      if (SEED_PRESTEP) begin : g_pre
         // R8: a pre-stepped legal seed stays out of lock-up
         a_r8_seed_safe: assert property (@(posedge clk) disable iff (!rst_n)
            (seed_vld && seed_val != LOCK_VAL) |=> state_o != LOCK_VAL);
      end else begin : g_dir
         // R7: seed stored as given, enable ignored
         a_r7_seed_direct: assert property (@(posedge clk) disable iff (!rst_n)
            seed_vld |=> state_o == $past(seed_val));
      end
   endgenerate

endmodule

bind lfsr_prng lfsr_prng_chk #(
   .WIDTH       (WIDTH),
   .FEEDBACK    (FEEDBACK),
   .SEED_PRESTEP(SEED_PRESTEP)
) u_lfsr_prng_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .step_en (step_en),
   .seed_vld(seed_vld),
   .seed_val(seed_val),
   .state_o (state_o)
);

// File: tb/lfsr_prng_bench.sv
module lfsr_prng_bench;
   import lfsr_pkg::*;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic        en;
   logic        sv;
   logic [15:0] sd_a;
   logic [4:0]  sd_b;
   logic [7:0]  sd_c;
   logic [6:0]  sd_d;
   logic [15:0] st_a;
   logic [4:0]  st_b;
   logic [7:0]  st_c;
   logic [6:0]  st_d;

   lfsr_prng #(.WIDTH(16), .FORM(FORM_FIB), .FEEDBACK(FB_XOR), .STEPS(1)) u_lfsr_prng (
      .clk(clk), .rst_n(rst_n), .step_en(en), .seed_vld(sv), .seed_val(sd_a), .state_o(st_a));

   lfsr_prng #(.WIDTH(5), .FORM(FORM_GALOIS), .FEEDBACK(FB_XNOR), .STEPS(1)) u_gal5 (
      .clk(clk), .rst_n(rst_n), .step_en(en), .seed_vld(sv), .seed_val(sd_b), .state_o(st_b));

   lfsr_prng #(.WIDTH(8), .FORM(FORM_FIB), .FEEDBACK(FB_XNOR), .STEPS(3), .SEED_PRESTEP(1'b1),
               .USE_INIT_SEED(1'b1), .INIT_SEED(8'hA5)) u_fib8 (
      .clk(clk), .rst_n(rst_n), .step_en(en), .seed_vld(sv), .seed_val(sd_c), .state_o(st_c));

   lfsr_prng #(.WIDTH(7), .FORM(FORM_GALOIS), .FEEDBACK(FB_XOR), .STEPS(2),
               .USE_INIT_SEED(1'b1), .INIT_SEED(7'h01)) u_gal7 (
      .clk(clk), .rst_n(rst_n), .step_en(en), .seed_vld(sv), .seed_val(sd_d), .state_o(st_d));

   // Per-configuration data taken from the requirements
   int          cw   [4] = '{16, 5, 8, 7};
   bit          cgal [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
   bit          cxn  [4] = '{1'b0, 1'b1, 1'b1, 1'b0};
   int          ck   [4] = '{1, 1, 3, 2};
   bit          cpre [4] = '{1'b0, 1'b0, 1'b1, 1'b0};
   logic [15:0] cmask[4] = '{16'hB400, 16'h0014, 16'h00B8, 16'h0060};
   int          cper [4] = '{65535, 31, 85, 127};

   logic [15:0] cur [4];
   always_comb begin
      cur[0] = st_a;
      cur[1] = {11'd0, st_b};
      cur[2] = {8'd0, st_c};
      cur[3] = {9'd0, st_d};
   end

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] mstep(input int w, input bit gal, input bit xn,
                                         input logic [15:0] mask, input logic [15:0] s);
      logic [15:0] r;
      logic        fb;
      logic [15:0] lim;
      lim = 16'((32'd1 << w) - 1);
      r   = '0;
      if (!gal) begin
         fb = (^(s & mask)) ^ xn;
         r  = (s << 1) | {15'd0, fb};
      end else begin
         fb   = s[w-1];
         r[0] = fb;
         for (int i = 1; i < w; i++) begin
            r[i] = mask[i-1] ? (s[i-1] ^ fb ^ xn) : s[i-1];
         end
      end
      return r & lim;
   endfunction

   function automatic logic [15:0] mstepn(input int idx, input logic [15:0] s);
      logic [15:0] r;
      r = s;
      for (int k = 0; k < ck[idx]; k++) r = mstep(cw[idx], cgal[idx], cxn[idx], cmask[idx], r);
      return r;
   endfunction

   function automatic string form_req(input int idx);
      return cgal[idx] ? "R2/R3" : "R1/R3";
   endfunction

   logic [15:0] model[4];
   logic [15:0] start[4];
   logic [15:0] prev [4];
   int          first[4];
   int          miss [4];
   int          nochg[4];
   int          lock [4];
   logic [15:0] bad_act[4];
   logic [15:0] bad_exp[4];

   initial begin
      rst_n = 1'b0;
      en    = 1'b0;
      sv    = 1'b0;
      sd_a  = 16'hACE1;
      sd_b  = 5'h13;
      sd_c  = 8'h3C;
      sd_d  = 7'h55;
      repeat (3) @(posedge clk);
      #1;
      // R9: only bit 0 defined, value depends on feedback
      chk(st_a[0] == 1'b1, "R9", "xor reset bit0", {15'd0, st_a[0]}, 16'd1);
      chk(st_b[0] == 1'b0, "R9", "xnor reset bit0", {15'd0, st_b[0]}, 16'd0);
      // R10: full constant seed on reset
      chk(st_c == 8'hA5, "R10", "init seed w8", {8'd0, st_c}, 16'h00A5);
      chk(st_d == 7'h01, "R10", "init seed w7", {9'd0, st_d}, 16'h0001);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      // R7: load together with enable, load wins
      en = 1'b1;
      sv = 1'b1;
      @(posedge clk);
      #1;
      en = 1'b0;
      sv = 1'b0;
      model[0] = {sd_a};
      model[1] = {11'd0, sd_b};
      model[2] = {8'd0, sd_c};
      model[3] = {9'd0, sd_d};
      for (int i = 0; i < 4; i++) begin
         if (cpre[i]) model[i] = mstepn(i, model[i]);
         chk(cur[i] == model[i], cpre[i] ? "R8" : "R7", "seed load", cur[i], model[i]);
      end
      // R6: idle holds
      repeat (3) @(posedge clk);
      #1;
      for (int i = 0; i < 4; i++) begin
         chk(cur[i] == model[i], "R6", "hold", cur[i], model[i]);
      end
      // Full-period run
      for (int i = 0; i < 4; i++) begin
         start[i] = model[i];
         first[i] = 0;
         miss[i]  = 0;
         nochg[i] = 0;
         lock[i]  = 0;
         bad_act[i] = '0;
         bad_exp[i] = '0;
      end
      en = 1'b1;
      for (int n = 1; n <= 65535; n++) begin
         for (int i = 0; i < 4; i++) prev[i] = cur[i];
         @(posedge clk);
         #1;
         for (int i = 0; i < 4; i++) begin
            model[i] = mstepn(i, model[i]);
            if (cur[i] != model[i]) begin
               if (miss[i] == 0) begin
                  bad_act[i] = cur[i];
                  bad_exp[i] = model[i];
               end
               miss[i]++;
            end
            if (cur[i] == prev[i]) nochg[i]++;
            if (cur[i] == (cxn[i] ? 16'((32'd1 << cw[i]) - 1) : 16'd0)) lock[i]++;
            if (first[i] == 0 && cur[i] == start[i]) first[i] = n;
         end
      end
      en = 1'b0;
      for (int i = 0; i < 4; i++) begin
         chk(miss[i] == 0, form_req(i), "step sequence", bad_act[i], bad_exp[i]);
         chk(nochg[i] == 0, "R5", "unchanged steps", 16'(nochg[i]), 16'd0);
         chk(lock[i] == 0, "R4", "lock-up visits", 16'(lock[i]), 16'd0);
         chk(first[i] == cper[i], "R11", "period", 16'(first[i]), 16'(cper[i]));
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule